// File: doc/BRIEF.md
# EDO DRAM Cycle Decoder with Parallel Test Mode

This block is a synthesizable, device-side model of the control logic of a single x4 EDO DRAM. A clock that is much faster than the strobes samples them. The block works out what kind of cycle the controller is running from the order in which the active-low RAS, CAS and WE strobes change. A small parameterized array stands in for the cell storage. Every decision becomes visible one clock after the sampling edge that sees the strobe change.

Besides ordinary reads, early writes and read-modify-writes, the block recognises two refresh forms: RAS-only refresh and CAS-before-RAS refresh. It also recognises a refresh variant that switches on a latched parallel-compare test mode. In test mode, writes are copied to a whole group of eight cells. A read does not return stored data. Each DQ pin instead reports whether its eight cells all hold the same value. Test mode stays set until the next plain refresh.

Top module: `edo_cyc_top`

## Requirements
- R1: If CAS is low and WE is high when RAS falls, the cycle is a CAS-before-RAS refresh. cycleType becomes 5 and testMode clears.
- R2: If CAS and WE are both low when RAS falls, the cycle is test entry. cycleType becomes 6 and testMode sets. testMode keeps its value through later cycles that are not refreshes.
- R3: If RAS falls with CAS high and then rises without any CAS fall in between, the cycle is a RAS-only refresh. cycleType becomes 4 and testMode clears.
- R4: If CAS falls while a row is open and WE is high, the cycle is a read. cycleType becomes 1, dqOut shows the word stored at the latched row and column, and dqOe is 1 while OE is low.
- R5: If WE is already low when CAS falls, the cycle is an early write. cycleType becomes 2, dqIn is stored, and dqOe stays 0.
- R6: If WE falls after CAS has fallen in a read, the cycle becomes a read-modify-write. The read data is shown first. When WE falls, cycleType becomes 3, dqIn is written to the same cell, and dqOe goes to 0.
- R7: After CAS rises with RAS still low, dqOe and dqOut keep their values. dqOe goes to 0 in any of three cases: RAS and CAS are both high, OE rises, or WE falls. OE going low again does not turn dqOe back on. Only a new CAS fall in a read does.
- R8: In test mode, a read drives each DQ bit high when all eight cells of its group hold equal values on that bit, and low when any of them differs.
- R9: In test mode, column bits 0, 1 and COL_W-1 are ignored. A write stores dqIn in all eight columns of the group at the open row, and a read may use any column of the group.
- R10: After reset, cycleType is 0, testMode is 0 and dqOe is 0.
- R11: If RAS falls with CAS high, cycleType becomes 0 (idle) until the cycle is classified. A CAS fall while RAS is high has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dqIn | input | DQ_W | Write data |
| dqOut | output | DQ_W | Read data, or per-pin compare result in test mode |
| dqOe | output | 1 | Output driver enable |
| cycleType | output | 3 | Code of the current or last cycle |
| testMode | output | 1 | Parallel test mode flag |

## Verification
The bench builds the block with its default parameters: ROW_W=2, COL_W=4, DQ_W=4. With these values column bit 2 is the only column bit that test mode keeps. The sixteen columns of a row therefore fall into exactly two eight-cell groups. Each group can be filled with a test write, probed at columns that differ only in the ignored bits, and compared against the other group after a normal write makes one cell differ. Both exits from test mode are reachable in a few hundred cycles: RAS-only refresh and CAS-before-RAS refresh.

// File: rtl/edo_cyc_pkg.sv
package edo_cyc_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE   = 3'd0,
    CYC_READ   = 3'd1,
    CYC_EWRITE = 3'd2,
    CYC_RMW    = 3'd3,
    CYC_ROREF  = 3'd4,
    CYC_CBR    = 3'd5,
    CYC_TEST   = 3'd6
  } cycType_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic rowLoad;
    logic colLoad;
    logic rdLoad;
    logic wrEn;
    logic testMode;
  } ctlStrobe_t;

endpackage

// File: rtl/edo_cyc_ctrl.sv
module edo_cyc_ctrl
  import edo_cyc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  input  logic       oeN,
  output ctlStrobe_t strb,
  output cycType_e   cycType,
  output logic       testMode,
  output logic       dqOe
);

  logic rasQ, casQ, weQ, oeQ;
  logic rowOpen, casSeen, validQ;
  logic rasFall, rasRise, weFall, oeRise;
  logic casFallAct, wrLate;

  // Edge detection against the previous sample
  assign rasFall    = rasQ & ~rasN;
  assign rasRise    = ~rasQ & rasN;
  assign weFall     = weQ & ~weN;
  assign oeRise     = ~oeQ & oeN;
  assign casFallAct = casQ & ~casN & ~rasN & rowOpen;
  assign wrLate     = weFall & ~casN & ~rasN & rowOpen & casSeen & ~casFallAct;

  always_comb begin
    strb.rowLoad  = rasFall & casN;
    strb.colLoad  = casFallAct;
    strb.rdLoad   = casFallAct & weN;
    strb.wrEn     = (casFallAct & ~weN) | wrLate;
    strb.testMode = testMode;
  end

  assign dqOe = validQ & ~oeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasQ     <= 1'b1;
      casQ     <= 1'b1;
      weQ      <= 1'b1;
      oeQ      <= 1'b1;
      rowOpen  <= 1'b0;
      casSeen  <= 1'b0;
      validQ   <= 1'b0;
      cycType  <= CYC_IDLE;
      testMode <= 1'b0;
    end else begin
      rasQ <= rasN;
      casQ <= casN;
      weQ  <= weN;
      oeQ  <= oeN;

      if (rasFall) begin
        if (!casN) begin
          rowOpen <= 1'b0;
          if (weN) begin
            cycType  <= CYC_CBR;
            testMode <= 1'b0;
          end else begin
            cycType  <= CYC_TEST;
            testMode <= 1'b1;
          end
        end else begin
          rowOpen <= 1'b1;
          casSeen <= 1'b0;
          cycType <= CYC_IDLE;
        end
      end else if (rasRise) begin
        rowOpen <= 1'b0;
        casSeen <= 1'b0;
        if (rowOpen && !casSeen) begin
          cycType  <= CYC_ROREF;
          testMode <= 1'b0;
        end
      end else if (casFallAct) begin
        casSeen <= 1'b1;
        cycType <= weN ? CYC_READ : CYC_EWRITE;
      end else if (wrLate && cycType == CYC_READ) begin
        cycType <= CYC_RMW;
      end

      // Output valid latch: clears take priority over the read set
      if (casFallAct && weN) validQ <= 1'b1;
      if (weFall || oeRise || (rasN && casN)) validQ <= 1'b0;
    end
  end

  assert_cbr_decode_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasN) && !casN && weN) |=> (cycType == CYC_CBR && !testMode));

  assert_test_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasN) && !casN && !weN) |=> (cycType == CYC_TEST && testMode));

  assert_test_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(testMode) |-> ($past(rasN) != $past(rasN, 2)));

  assert_rmw_decode_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(weN) && !casN && $stable(casN) && !rasN && $stable(rasN) &&
     cycType == CYC_READ) |=> (cycType == CYC_RMW && !dqOe));

  assert_we_blank_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(weN) |-> !dqOe);

  assert_oe_blank_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(oeN) |-> !dqOe);

  assert_idle_blank_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rasN && casN) |-> !dqOe);

endmodule

// File: rtl/edo_cyc_dp.sv
module edo_cyc_dp
  import edo_cyc_pkg::*;
#(
  parameter int ROW_W  = 2,
  parameter int COL_W  = 4,
  parameter int DQ_W   = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dqIn,
  output logic [DQ_W-1:0]   dqOut
);

  localparam int ROWS  = 1 << ROW_W;
  localparam int COLS  = 1 << COL_W;
  localparam int DEPTH = ROWS * COLS;
  localparam int IDX_W = ROW_W + COL_W;
  // Column bits that test mode ignores: 0, 1 and the top bit
  localparam logic [COL_W-1:0] IGNORE_MASK = {1'b1, {(COL_W-3){1'b0}}, 2'b11};
  localparam logic [COL_W-1:0] KEEP_MASK   = ~IGNORE_MASK;

  logic [ROW_W-1:0] rowQ;
  logic [COL_W-1:0] colQ, colAddr;
  logic [DQ_W-1:0]  mem [DEPTH];
  logic [COLS-1:0]  groupHit;
  logic [DQ_W-1:0]  allOne, anyOne, foldVal;

  function automatic logic [IDX_W-1:0] cellIdx(logic [ROW_W-1:0] r, logic [COL_W-1:0] c);
    return {r, c};
  endfunction

  assign colAddr = strb.colLoad ? addr[COL_W-1:0] : colQ;

  for (genvar c = 0; c < COLS; c++) begin : g_hit
    assign groupHit[c] = ((COL_W'(c) ^ colAddr) & KEEP_MASK) == '0;
  end

  // Per-pin compare over the eight cells of the group
  always_comb begin
    allOne = '1;
    anyOne = '0;
    for (int c = 0; c < COLS; c++) begin
      if (groupHit[c]) begin
        allOne &= mem[cellIdx(rowQ, COL_W'(c))];
        anyOne |= mem[cellIdx(rowQ, COL_W'(c))];
      end
    end
    foldVal = allOne | ~anyOne;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ <= '0;
      colQ <= '0;
    end else begin
      if (strb.rowLoad) rowQ <= addr[ROW_W-1:0];
      if (strb.colLoad) colQ <= addr[COL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strb.wrEn) begin
      if (strb.testMode) begin
        for (int c = 0; c < COLS; c++) begin
          if (groupHit[c]) mem[cellIdx(rowQ, COL_W'(c))] <= dqIn;
        end
      end else begin
        mem[cellIdx(rowQ, colAddr)] <= dqIn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dqOut <= '0;
    end else if (strb.rdLoad) begin
      dqOut <= strb.testMode ? foldVal : mem[cellIdx(rowQ, colAddr)];
    end
  end

  assert_dq_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdLoad |=> $stable(dqOut));

  assert_no_write_at_row_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.rowLoad |-> !strb.wrEn && !strb.rdLoad);

endmodule

// File: rtl/edo_cyc_top.sv
module edo_cyc_top
  import edo_cyc_pkg::*;
#(
  parameter int ROW_W  = 2,
  parameter int COL_W  = 4,
  parameter int DQ_W   = 4,
  parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dqIn,
  output logic [DQ_W-1:0]   dqOut,
  output logic              dqOe,
  output logic [2:0]        cycleType,
  output logic              testMode
);

  ctlStrobe_t strb;
  cycType_e   cycTypeW;

  edo_cyc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .oeN      (oeN),
    .strb     (strb),
    .cycType  (cycTypeW),
    .testMode (testMode),
    .dqOe     (dqOe)
  );

  edo_cyc_dp #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DQ_W   (DQ_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .addr  (addr),
    .dqIn  (dqIn),
    .dqOut (dqOut)
  );

  assign cycleType = cycTypeW;

endmodule

// File: tb/edo_cyc_top_tb_top.sv
`timescale 1ns/1ps
module edo_cyc_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rasN = 1'b1, casN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [3:0] addr = '0;
  logic [3:0] dqIn = '0;
  logic [3:0] dqOut;
  logic       dqOe;
  logic [2:0] cycleType;
  logic       testMode;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  edo_cyc_top dut_i (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe),
    .cycleType(cycleType), .testMode(testMode)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic openRow(logic [3:0] row);
    addr = row;
    rasN = 1'b0;
    tick();
  endtask

  task automatic closeAll();
    casN = 1'b1; rasN = 1'b1; weN = 1'b1;
    tick();
  endtask

  task automatic earlyWrite(logic [3:0] row, logic [3:0] col, logic [3:0] data);
    openRow(row);
    addr = col; dqIn = data; weN = 1'b0;
    tick();
    casN = 1'b0;
    tick();
    chk("R5", "early write code", cycleType, 3'd2);
    chk("R5", "early write dqOe", dqOe, 1'b0);
    closeAll();
  endtask

  task automatic readWord(logic [3:0] row, logic [3:0] col, output logic [3:0] d, output logic oe);
    openRow(row);
    addr = col; oeN = 1'b0; casN = 1'b0;
    tick();
    d = dqOut;
    oe = dqOe;
    chk("R4", "read code", cycleType, 3'd1);
    closeAll();
  endtask

  task automatic testReset();
    chk("R10", "reset cycleType", cycleType, 3'd0);
    chk("R10", "reset testMode", testMode, 1'b0);
    chk("R10", "reset dqOe", dqOe, 1'b0);
  endtask

  task automatic testEarlyWrite();
    casN = 1'b0;            // CAS fall with RAS high: no effect (R11)
    tick();
    chk("R11", "CAS while RAS high", cycleType, 3'd0);
    casN = 1'b1;
    tick();
    openRow(4'd1);
    chk("R11", "idle after row open", cycleType, 3'd0);
    closeAll();
    earlyWrite(4'd1, 4'd5, 4'hA);
  endtask

  task automatic testReadEdo();
    openRow(4'd1);
    addr = 4'd5; oeN = 1'b0; casN = 1'b0;
    tick();
    chk("R4", "read code", cycleType, 3'd1);
    chk("R4", "read dqOe", dqOe, 1'b1);
    chk("R4", "read data", dqOut, 4'hA);
    casN = 1'b1;
    tick();
    chk("R7", "EDO hold dqOe", dqOe, 1'b1);
    chk("R7", "EDO hold data", dqOut, 4'hA);
    oeN = 1'b1;
    tick();
    chk("R7", "OE rise blanks", dqOe, 1'b0);
    oeN = 1'b0;
    tick();
    chk("R7", "OE low again stays off", dqOe, 1'b0);
    casN = 1'b0;
    tick();
    chk("R7", "page CAS re-enables", dqOe, 1'b1);
    casN = 1'b1; rasN = 1'b1;
    tick();
    chk("R7", "RAS and CAS high blank", dqOe, 1'b0);
    tick();
  endtask

  task automatic testRmw();
    logic [3:0] d;
    logic oe;
    openRow(4'd1);
    addr = 4'd5; oeN = 1'b0; casN = 1'b0;
    tick();
    chk("R6", "RMW read phase data", dqOut, 4'hA);
    chk("R6", "RMW read phase dqOe", dqOe, 1'b1);
    dqIn = 4'h3; weN = 1'b0;
    tick();
    chk("R6", "RMW code", cycleType, 3'd3);
    chk("R7", "WE low blanks", dqOe, 1'b0);
    closeAll();
    readWord(4'd1, 4'd5, d, oe);
    chk("R6", "RMW stored data", d, 4'h3);
  endtask

  task automatic testRasOnly();
    openRow(4'd0);
    rasN = 1'b1;
    tick();
    chk("R3", "RAS-only code", cycleType, 3'd4);
  endtask

  task automatic testCbr();
    casN = 1'b0;
    tick();
    rasN = 1'b0;
    tick();
    chk("R1", "CBR code", cycleType, 3'd5);
    chk("R1", "CBR testMode", testMode, 1'b0);
    closeAll();
  endtask

  task automatic enterTest();
    casN = 1'b0; weN = 1'b0;
    tick();
    rasN = 1'b0;
    tick();
    chk("R2", "entry code", cycleType, 3'd6);
    chk("R2", "entry flag", testMode, 1'b1);
    closeAll();
  endtask

  task automatic testParallel();
    logic [3:0] d;
    logic oe;
    enterTest();
    tick();
    chk("R2", "flag held", testMode, 1'b1);
    earlyWrite(4'd2, 4'd0, 4'hA);          // fills columns 0-3 and 8-11
    chk("R2", "flag held after write", testMode, 1'b1);
    readWord(4'd2, 4'd9, d, oe);
    chk("R8", "all equal fold", d, 4'hF);
    chk("R8", "fold dqOe", oe, 1'b1);
    readWord(4'd2, 4'd11, d, oe);
    chk("R9", "ignored bits same group", d, 4'hF);
    testRasOnly();
    chk("R3", "RAS-only clears test", testMode, 1'b0);
    readWord(4'd2, 4'd3, d, oe);
    chk("R9", "replicated col3", d, 4'hA);
    readWord(4'd2, 4'd10, d, oe);
    chk("R9", "replicated col10", d, 4'hA);
    readWord(4'd2, 4'd4, d, oe);
    chk("R9", "other group untouched", d, 4'h0);
    earlyWrite(4'd2, 4'd8, 4'h6);
    enterTest();
    readWord(4'd2, 4'd0, d, oe);
    chk("R8", "mismatch fold", d, 4'h3);   // A vs 6: bits 2,3 differ
    readWord(4'd2, 4'd6, d, oe);
    chk("R8", "second group fold", d, 4'hF);
    testCbr();
  endtask

  initial begin
    repeat (4) tick();
    rstN = 1'b1;
    tick();
    testReset();
    testEarlyWrite();
    testReadEdo();
    testRmw();
    testRasOnly();
    testCbr();
    testParallel();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule